// File: doc/BRIEF.md
# SPI Serial Byte Memory with Block Protection

This block is a serial-peripheral slave that sits in front of a 2 KB byte-addressed register array. A host selects it with an active-low chip select and clocks in a one-byte command. Address and data bytes follow where the command needs them. All bytes travel most significant bit first. The host may idle the serial clock low or high, so clock modes 0 and 3 are both accepted. The serial lines are oversampled by the system clock: every serial edge is rebuilt from synchronized samples, so the serial clock must be several times slower than the system clock.

A status byte holds three groups of settings: a two-bit protection level that shields the top quarter, the top half or all of the array from writes; a two-bit watchdog period selection that is stored for a neighbouring block; and a lock-enable bit. When the lock-enable bit is set and the write-protect pin is held low, the status byte cannot be changed. Page writes gather up to a page of bytes in a buffer. They are committed only when chip select is released on a byte boundary. Each committed write starts a self-timed busy period whose length is a cycle-count parameter, and during it only status reads are honoured.

Top module: `spi_prot_mem`

## Requirements
- R1: SI is sampled on serial clock rising edges and SO changes on falling edges, MSB first. A transaction started with the clock idling high (mode 3) returns the same data as one started with it idling low (mode 0).
- R2: so_oe_o is 0 whenever cs_ni is high. It is 1 while a selected transaction is in progress.
- R3: After reset, no command is accepted and SO is not driven until cs_ni has been seen going from high to low.
- R4: Command 0x03, followed by a 16-bit address, returns array bytes from that address onward. Only the low 11 address bits are used. The address increments after each byte and wraps from 0x7FF to 0x000.
- R5: Command 0x02, followed by a 16-bit address and 1 to 32 data bytes, writes them into one 32-byte page. The offset within the page wraps from 31 to 0, and no byte lands outside the page.
- R6: Command 0x06 sets the write-enable bit (status bit 1) and 0x04 clears it. A memory or status write made while this bit is clear has no effect. Every committed write clears the bit.
- R7: A memory or status write is committed only if cs_ni rises after a whole number of bytes. Otherwise the array and the status byte are unchanged.
- R8: Command 0x05 returns the status byte: bit 0 busy, bit 1 write enable, bits 3:2 protection level, bits 5:4 watchdog select, bit 7 lock enable, bit 6 zero. Command 0x01 followed by one byte updates bits 7 and 5:2 from that byte and ignores its other bits.
- R9: A committed write holds the busy bit for BUSY_CYC system clock cycles. While it is set, every command except 0x05 is ignored.
- R10: Protection level 1 blocks writes to 0x600–0x7FF, level 2 blocks writes to 0x400–0x7FF, and level 3 blocks all writes. A blocked page write leaves the array unchanged, starts no busy period and keeps the write-enable bit.
- R11: While the lock-enable bit is 1 and wp_ni is 0, command 0x01 is rejected and the status byte, including the write-enable bit, stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data from the host |
| wp_ni | input | 1 | Active-low write-protect pin, combined with the lock-enable bit |
| so_o | output | 1 | Serial data to the host |
| so_oe_o | output | 1 | Output enable for so_o; low means high impedance |

## Verification
The bench targets the boundaries where a serial memory tends to go wrong. It writes a page that starts four bytes before the end of its page: a design that carries the offset into the next page corrupts address 0x060 instead of wrapping to 0x040. It reads across the top of the array, which a design without the wrap would return as garbage or stall on. It releases chip select three bits into a data byte, which a design without byte-boundary gating would commit. It probes the protection limits one address either side of 0x600 and 0x400, where a wrong address decode blocks or allows the neighbouring byte. It also checks the rules that must hold no matter what state the block is in: the lock with the pin low, write enable being ignored during the busy period, and bytes clocked with chip select held low since reset, which must not arm a write.

// File: rtl/spm_pkg.sv
package spm_pkg;

  typedef enum logic [7:0] {
    OP_WRSR  = 8'h01,
    OP_WRITE = 8'h02,
    OP_READ  = 8'h03,
    OP_WRDI  = 8'h04,
    OP_RDSR  = 8'h05,
    OP_WREN  = 8'h06
  } spm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR_H,
    ST_ADDR_L,
    ST_READ,
    ST_WRITE,
    ST_SR_RD,
    ST_SR_WR
  } spm_st_e;

  typedef struct packed {
    logic       lock_en;
    logic       rsvd;
    logic [1:0] wd_sel;
    logic [1:0] prot_lvl;
    logic       wr_en;
    logic       busy;
  } spm_status_t;

endpackage

// File: rtl/spm_sync.sv
module spm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spm_spi_if.sv
module spm_spi_if #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       si_i,
  input  logic       wp_ni,
  input  logic [7:0] tx_byte_i,
  output logic       so_o,
  output logic       sess_o,
  output logic       cs_fall_o,
  output logic       cs_rise_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       aligned_o,
  output logic       wp_s_o
);
  logic [3:0] s;
  logic       sck_q, cs_q, sess_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] rx_sr_q, tx_sr_q;
  logic       sck_rise, sck_fall;

  // sync flops reset to 0: a cs_ni held low through reset yields no falling edge
  spm_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wp_ni, si_i, cs_ni, sck_i}),
    .q_o   (s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      sck_q <= s[0];
      cs_q  <= s[1];
    end
  end

  assign sck_rise  = s[0] & ~sck_q;
  assign sck_fall  = ~s[0] & sck_q;
  assign cs_fall_o = ~s[1] & cs_q;
  assign cs_rise_o = s[1] & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sess_q    <= 1'b0;
      bit_cnt_q <= '0;
      rx_sr_q   <= '0;
      tx_sr_q   <= '0;
    end else begin
      if (cs_fall_o) begin
        sess_q    <= 1'b1;
        bit_cnt_q <= '0;
      end else if (cs_rise_o) begin
        sess_q <= 1'b0;
      end else if (sess_q && sck_rise) begin
        bit_cnt_q <= bit_cnt_q + 3'd1;
        rx_sr_q   <= {rx_sr_q[6:0], s[2]};
      end
      if (sess_q && sck_fall) begin
        if (bit_cnt_q == '0) tx_sr_q <= tx_byte_i;
        else                 tx_sr_q <= {tx_sr_q[6:0], 1'b0};
      end
    end
  end

  assign byte_done_o = sess_q & sck_rise & (bit_cnt_q == 3'd7);
  assign rx_byte_o   = {rx_sr_q[6:0], s[2]};
  assign aligned_o   = (bit_cnt_q == '0);
  assign so_o        = tx_sr_q[7];
  assign sess_o      = sess_q;
  assign wp_s_o      = s[3];
endmodule

// File: rtl/spm_core.sv
module spm_core
  import spm_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32,
  parameter int BUSY_CYC   = 250000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_fall_i,
  input  logic       cs_rise_i,
  input  logic       byte_done_i,
  input  logic [7:0] rx_byte_i,
  input  logic       aligned_i,
  input  logic       wp_ni,
  output logic [7:0] tx_byte_o,
  output logic [7:0] status_o,
  output logic       commit_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - OFF_W;
  localparam int HI_W   = ADDR_W - 8;
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);

  spm_st_e            st_q;
  logic               is_rd_q;
  logic [HI_W-1:0]    addr_hi_q;
  logic [ADDR_W-1:0]  rd_ptr_q;
  logic [PG_W-1:0]    pg_q;
  logic [OFF_W-1:0]   off_q;
  logic [PAGE_BYTES-1:0] vmask_q;
  logic [7:0]         pbuf_q [PAGE_BYTES];
  logic [4:0]         sr_new_q;   // {lock_en, wd_sel, prot_lvl}
  logic               sr_got_q;
  logic [7:0]         tx_q;
  logic [7:0]         mem_q [DEPTH];
  logic               wel_q, lock_q;
  logic [1:0]         lvl_q, wd_q;
  logic [BUSY_W-1:0]  busy_q;
  logic [ADDR_W-1:0]  full_addr;
  logic               wip, wr_commit, sr_commit, cmd_ok;
  spm_status_t        status;

  function automatic logic is_prot(input logic [1:0] lvl, input logic [PG_W-1:0] pg);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return &pg[PG_W-1 -: 2];
      2'd2:    return pg[PG_W-1];
      default: return 1'b1;
    endcase
  endfunction

  assign wip       = (busy_q != '0);
  assign full_addr = {addr_hi_q, rx_byte_i};
  assign cmd_ok    = byte_done_i && (st_q == ST_CMD) && !wip;
  assign status    = '{lock_en: lock_q, rsvd: 1'b0, wd_sel: wd_q,
                       prot_lvl: lvl_q, wr_en: wel_q, busy: wip};

  assign wr_commit = cs_rise_i && aligned_i && (st_q == ST_WRITE) && (|vmask_q)
                     && wel_q && !is_prot(lvl_q, pg_q);
  assign sr_commit = cs_rise_i && aligned_i && (st_q == ST_SR_WR) && sr_got_q
                     && wel_q && !(lock_q && !wp_ni);

  // transaction sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      is_rd_q   <= 1'b0;
      addr_hi_q <= '0;
      rd_ptr_q  <= '0;
      pg_q      <= '0;
      off_q     <= '0;
      vmask_q   <= '0;
      sr_new_q  <= '0;
      sr_got_q  <= 1'b0;
      tx_q      <= '0;
    end else if (cs_fall_i) begin
      st_q <= ST_CMD;
    end else if (cs_rise_i) begin
      st_q <= ST_IDLE;
    end else if (byte_done_i) begin
      case (st_q)
        ST_CMD: begin
          st_q <= ST_IDLE;
          if (!wip || rx_byte_i == OP_RDSR) begin
            case (rx_byte_i)
              OP_RDSR:  begin tx_q <= status; st_q <= ST_SR_RD; end
              OP_WRSR:  begin sr_got_q <= 1'b0; st_q <= ST_SR_WR; end
              OP_READ:  begin is_rd_q <= 1'b1; st_q <= ST_ADDR_H; end
              OP_WRITE: begin is_rd_q <= 1'b0; st_q <= ST_ADDR_H; end
              default:  st_q <= ST_IDLE;
            endcase
          end
        end
        ST_ADDR_H: begin
          addr_hi_q <= rx_byte_i[HI_W-1:0];
          st_q      <= ST_ADDR_L;
        end
        ST_ADDR_L: begin
          if (is_rd_q) begin
            tx_q     <= mem_q[full_addr];
            rd_ptr_q <= full_addr + 1'b1;
            st_q     <= ST_READ;
          end else begin
            pg_q    <= full_addr[ADDR_W-1:OFF_W];
            off_q   <= full_addr[OFF_W-1:0];
            vmask_q <= '0;
            st_q    <= ST_WRITE;
          end
        end
        ST_READ: begin
          tx_q     <= mem_q[rd_ptr_q];
          rd_ptr_q <= rd_ptr_q + 1'b1;
        end
        ST_SR_RD: tx_q <= status;
        ST_SR_WR: begin
          if (!sr_got_q) begin
            sr_new_q <= {rx_byte_i[7], rx_byte_i[5:2]};
            sr_got_q <= 1'b1;
          end
        end
        ST_WRITE: begin
          vmask_q[off_q] <= 1'b1;
          off_q          <= off_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= '0;
    end else if (byte_done_i && st_q == ST_WRITE) begin
      pbuf_q[off_q] <= rx_byte_i;
    end
  end

  // status byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      lvl_q  <= '0;
      wd_q   <= '0;
      lock_q <= 1'b0;
    end else if (wr_commit || sr_commit) begin
      wel_q <= 1'b0;
      if (sr_commit) begin
        lock_q <= sr_new_q[4];
        wd_q   <= sr_new_q[3:2];
        lvl_q  <= sr_new_q[1:0];
      end
    end else if (cmd_ok) begin
      if (rx_byte_i == OP_WREN)      wel_q <= 1'b1;
      else if (rx_byte_i == OP_WRDI) wel_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     busy_q <= '0;
    else if (wr_commit || sr_commit) busy_q <= BUSY_W'(BUSY_CYC);
    else if (wip)                    busy_q <= busy_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
    end else if (wr_commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (vmask_q[i]) mem_q[{pg_q, OFF_W'(i)}] <= pbuf_q[i];
    end
  end

  assign tx_byte_o = tx_q;
  assign status_o  = status;
  assign commit_o  = wr_commit | sr_commit;
endmodule

// File: rtl/spi_prot_mem.sv
module spi_prot_mem #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYC    = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  input  logic wp_ni,
  output logic so_o,
  output logic so_oe_o
);
  logic       sess_w, cs_fall_w, cs_rise_w, byte_done_w, aligned_w, wp_s_w, commit_w;
  logic [7:0] rx_w, tx_w, status_w;

  spm_spi_if #(.SYNC_STAGES(SYNC_STAGES)) u_if (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .cs_ni      (cs_ni),
    .si_i       (si_i),
    .wp_ni      (wp_ni),
    .tx_byte_i  (tx_w),
    .so_o       (so_o),
    .sess_o     (sess_w),
    .cs_fall_o  (cs_fall_w),
    .cs_rise_o  (cs_rise_w),
    .byte_done_o(byte_done_w),
    .rx_byte_o  (rx_w),
    .aligned_o  (aligned_w),
    .wp_s_o     (wp_s_w)
  );

  spm_core #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES),
    .BUSY_CYC  (BUSY_CYC)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_fall_i  (cs_fall_w),
    .cs_rise_i  (cs_rise_w),
    .byte_done_i(byte_done_w),
    .rx_byte_i  (rx_w),
    .aligned_i  (aligned_w),
    .wp_ni      (wp_s_w),
    .tx_byte_o  (tx_w),
    .status_o   (status_w),
    .commit_o   (commit_w)
  );

  // raw pin gates the driver so deselect releases SO at once
  assign so_oe_o = sess_w & ~cs_ni;
endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
  parameter int BUSY_CYC = 250000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       so_oe_i,
  input logic       cs_rise_i,
  input logic       commit_i,
  input logic [7:0] status_i
);
  logic [31:0] wip_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wip_run_q <= '0;
    else if (status_i[0]) wip_run_q <= wip_run_q + 32'd1;
    else                  wip_run_q <= '0;
  end

  // R2: a seen deselect leaves SO released
  assert_oe_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> !so_oe_i);

  // R6: commit drops write enable and raises busy
  assert_wel_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (!status_i[1] && status_i[0]));

  // R9: settings frozen while busy
  assert_sr_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[0] |=> (status_i[7:1] == $past(status_i[7:1])));

  // R9: busy never outlasts its budget
  assert_busy_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[0] |-> (wip_run_q < 32'(BUSY_CYC)));
endmodule

bind spi_prot_mem spm_checker #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .so_oe_i  (so_oe_o),
  .cs_rise_i(cs_rise_w),
  .commit_i (commit_w),
  .status_i (status_w)
);

// File: tb/spi_prot_mem_tb.sv
module spi_prot_mem_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8 * CLK_PERIOD;
  localparam int BUSY       = 600;
  localparam int NVEC       = 6;
  // {address16, data}
  localparam logic [23:0] VEC [NVEC] = '{
    {16'h0000, 8'h3C}, {16'h07FF, 8'hC5}, {16'hF9AB, 8'h5A},
    {16'h0123, 8'h81}, {16'h0400, 8'hE7}, {16'h0600, 8'h99}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe;
  logic mode3 = 1'b0;
  logic [7:0] pbuf [40];
  logic [7:0] rbuf [40];
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  spi_prot_mem #(.BUSY_CYC(BUSY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n),
    .si_i(si), .wp_ni(wp_n), .so_o(so), .so_oe_o(so_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      if (mode3) sck = 1'b0;
      si = tx[i];
      #(HALF);
      rx[i] = so;
      sck = 1'b1;
      #(HALF);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic sel();
    sck = mode3;
    cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic desel();
    #(HALF);
    cs_n = 1'b1;
    #(6*CLK_PERIOD);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h01, d); xfer(v, d); desel();
  endtask

  task automatic page_write(input logic [15:0] a, input int n);
    logic [7:0] d;
    sel(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(pbuf[i], d);
    desel();
  endtask

  task automatic read_n(input logic [15:0] a, input int n);
    logic [7:0] d;
    sel(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
    desel();
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] s;
    bit done = 0;
    for (int k = 0; k < 50 && !done; k++) begin
      rdsr(s);
      if (!s[0]) done = 1;
    end
    n_run++;
    if (!done) begin
      n_fail++;
      $display("FAIL %s busy bit: actual 1 expected 0", req);
    end
  endtask

  task automatic write1(input logic [15:0] a, input logic [7:0] v);
    pbuf[0] = v;
    page_write(a, 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(150000 * CLK_PERIOD);
    n_fail++;
    $display("FAIL all watchdog expired: actual hung expected done");
    summary();
  end

  initial begin
    logic [7:0] s, d;
    // R3: chip select low through reset, no falling edge seen
    #(4*CLK_PERIOD);
    rst_n = 1'b1;
    #(6*CLK_PERIOD);
    chk("R2", "so_oe after reset", {7'd0, so_oe}, 8'h00);
    xfer(8'h06, d);
    chk("R3", "so_oe with no select edge", {7'd0, so_oe}, 8'h00);
    cs_n = 1'b1;
    #(6*CLK_PERIOD);
    rdsr(s);
    chk("R3", "status after unarmed WREN", s, 8'h00);
    chk("R8", "reset status", s, 8'h00);

    // vector loop: single-byte write then readback
    for (int v = 0; v < NVEC; v++) begin
      cmd1(8'h06);
      write1(VEC[v][23:8], VEC[v][7:0]);
      wait_idle("R9");
      read_n({5'd0, VEC[v][18:8]}, 1);
      chk("R4", $sformatf("vector %0d readback", v), rbuf[0], VEC[v][7:0]);
    end

    // R2: output enable while selected
    sel(); xfer(8'h05, d);
    chk("R2", "so_oe while selected", {7'd0, so_oe}, 8'h01);
    xfer(8'h00, d); desel();
    chk("R2", "so_oe after deselect", {7'd0, so_oe}, 8'h00);

    // R6: write enable set and clear
    cmd1(8'h06); rdsr(s);
    chk("R6", "status after WREN", s, 8'h02);
    cmd1(8'h04); rdsr(s);
    chk("R6", "status after WRDI", s, 8'h00);
    write1(16'h0100, 8'h55);
    read_n(16'h0100, 1);
    chk("R6", "write without enable ignored", rbuf[0], 8'h00);

    // R5: page wrap
    cmd1(8'h06);
    for (int i = 0; i < 8; i++) pbuf[i] = 8'hA0 + 8'(i);
    page_write(16'h005C, 8);
    wait_idle("R5");
    read_n(16'h005C, 4);
    for (int i = 0; i < 4; i++) chk("R5", "bytes before wrap", rbuf[i], 8'hA0 + 8'(i));
    read_n(16'h0040, 4);
    for (int i = 0; i < 4; i++) chk("R5", "bytes after wrap", rbuf[i], 8'hA4 + 8'(i));
    read_n(16'h0060, 1);
    chk("R5", "next page untouched", rbuf[0], 8'h00);
    rdsr(s);
    chk("R6", "enable cleared by commit", s, 8'h00);

    // R4: read wraps at array end
    read_n(16'h07FF, 2);
    chk("R4", "read at top", rbuf[0], 8'hC5);
    chk("R4", "read wrapped to zero", rbuf[1], 8'h3C);

    // R1: mode 3
    mode3 = 1'b1;
    read_n(16'h005C, 2);
    chk("R1", "mode3 read byte0", rbuf[0], 8'hA0);
    chk("R1", "mode3 read byte1", rbuf[1], 8'hA1);
    cmd1(8'h06);
    write1(16'h0300, 8'h6D);
    wait_idle("R1");
    mode3 = 1'b0;
    sck = 1'b0;
    read_n(16'h0300, 1);
    chk("R1", "mode3 write, mode0 read", rbuf[0], 8'h6D);

    // R9: busy period
    cmd1(8'h06);
    write1(16'h0310, 8'h12);
    rdsr(s);
    chk("R9", "busy bit set", {7'd0, s[0]}, 8'h01);
    cmd1(8'h06);
    wait_idle("R9");
    rdsr(s);
    chk("R9", "WREN ignored while busy", s, 8'h00);

    // R7: release in mid byte
    cmd1(8'h06);
    sel(); xfer(8'h02, d); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h77, d);
    for (int i = 0; i < 3; i++) begin
      si = 1'b1; #(HALF); sck = 1'b1; #(HALF); sck = 1'b0;
    end
    desel();
    read_n(16'h0200, 1);
    chk("R7", "partial byte not committed", rbuf[0], 8'h00);
    rdsr(s);
    chk("R7", "enable kept, not busy", s, 8'h02);

    // R8: status write, low bits ignored
    wrsr(8'h97);
    wait_idle("R8");
    rdsr(s);
    chk("R8", "status after write 0x97", s, 8'h94);

    // R10: upper quarter protected
    cmd1(8'h06);
    write1(16'h0600, 8'h11);
    rdsr(s);
    chk("R10", "blocked write keeps enable", s, 8'h96);
    read_n(16'h0600, 1);
    chk("R10", "0x600 unchanged", rbuf[0], 8'h99);
    write1(16'h05FF, 8'h22);
    wait_idle("R10");
    read_n(16'h05FF, 1);
    chk("R10", "0x5FF writable", rbuf[0], 8'h22);

    // R11: lock with pin low
    cmd1(8'h06);
    wp_n = 1'b0;
    #(6*CLK_PERIOD);
    wrsr(8'h00);
    rdsr(s);
    chk("R11", "locked status unchanged", s, 8'h96);
    wp_n = 1'b1;
    #(6*CLK_PERIOD);
    wrsr(8'h08);
    wait_idle("R11");
    rdsr(s);
    chk("R11", "unlocked status write", s, 8'h08);

    // R10: upper half, then all
    cmd1(8'h06);
    write1(16'h0400, 8'h44);
    read_n(16'h0400, 1);
    chk("R10", "0x400 blocked at level 2", rbuf[0], 8'hE7);
    write1(16'h03FF, 8'h33);
    wait_idle("R10");
    read_n(16'h03FF, 1);
    chk("R10", "0x3FF writable at level 2", rbuf[0], 8'h33);
    cmd1(8'h06);
    wrsr(8'h0C);
    wait_idle("R10");
    cmd1(8'h06);
    write1(16'h0000, 8'h01);
    read_n(16'h0000, 1);
    chk("R10", "0x000 blocked at level 3", rbuf[0], 8'h3C);

    summary();
  end
endmodule